// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block sits between an 8-bit CPU and a 24-bit system bus. It widens the CPU's 16-bit logical address into a bus address. Two page registers, written through I/O port writes, pick the 16K physical window that each half of the logical space lands on. The CPU's A15 selects the register: the low page register serves A15=0 and the high page register serves A15=1. Bits 7:2 of the selected register become bus bits A19:A14, and CPU bits A13:A0 pass through unchanged. Windows can only be placed within the first megabyte. During I/O cycles the bus carries only the 8-bit port number.

The same block decodes a boot PROM that sits at a fixed 1K-aligned logical base. Because the decode looks only at the logical address, the PROM answers in every 64K segment. Software switches the PROM out of the map by setting bit 0 of the high page register. Four indicator outputs show bus bits A19:A16.

Top module: `page_window_xlat`

## Requirements
- R1: After reset the low page register holds 00H, the high page register holds 0CH, and the PROM is enabled. Logical 0000-3FFF and C000-FFFF then map onto the same bus addresses.
- R2: In a memory cycle with A15=0, bus_addr = {4'h0, low[7:2], cpu_addr[13:0]}.
- R3: In a memory cycle with A15=1, bus_addr = {4'h0, high[7:2], cpu_addr[13:0]}.
- R4: An I/O write (bus_mem=0, bus_wr=1) loads cpu_data into the low page register at port PORT_BASE (D2H) and into the high page register at PORT_BASE+1 (D3H). The new value takes effect from the next clock cycle. Writes to any other port, I/O reads and memory writes change neither register.
- R5: bus_addr[23:20] is zero in every cycle.
- R6: In an I/O cycle, bus_addr = {16'h0000, io_port}.
- R7: prom_sel is 1 in a memory read whose cpu_addr lies in [PROM_BASE, PROM_BASE + PROM_KB*1024). With the defaults this is F000-FFFF. The decode is independent of the page registers, and the PROM is enabled.
- R8: Bit 0 of the high page register disables the PROM when 1 and enables it when 0. Bits 1:0 of either register never affect bus_addr.
- R9: prom_sel is 0 in every memory write and every I/O cycle.
- R10: addr_led equals bus_addr[19:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU logical address |
| bus_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cpu_data | input | 8 | CPU data bus, used for register writes |
| io_port | input | 8 | I/O port address of the current cycle |
| bus_addr | output | 24 | System bus address |
| prom_sel | output | 1 | Boot PROM select |
| addr_led | output | 4 | Indicator drive for bus A19:A16 |

## Verification
A corrupted or stale page register appears at the ports on the first memory access to the affected half of the logical space. Bus bits A19:A14 then differ from the value last written, and the indicators may also differ. A wrong disable bit appears on the next read inside the PROM range, where prom_sel has the wrong value. The bench compares every port against its model on every clock, so any such error is reported in the first cycle that exposes it.

// File: rtl/page_window_xlat.sv
module page_window_xlat #(
  parameter logic [7:0]  PORT_BASE = 8'hD2,
  parameter logic [15:0] PROM_BASE = 16'hF000,
  parameter int          PROM_KB   = 4,
  parameter logic [7:0]  LO_RESET  = 8'h00,
  parameter logic [7:0]  HI_RESET  = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        bus_mem,
  input  logic        bus_wr,
  input  logic [7:0]  cpu_data,
  input  logic [7:0]  io_port,
  output logic [23:0] bus_addr,
  output logic        prom_sel,
  output logic [3:0]  addr_led
);
  localparam logic [6:0] KB_FIRST = {1'b0, PROM_BASE[15:10]};
  localparam logic [6:0] KB_END   = KB_FIRST + 7'(PROM_KB);

  logic [7:0] page_lo, page_hi;
  logic [7:0] sel_page;
  logic       io_wr, wr_lo, wr_hi, in_prom;
  logic [6:0] kb_idx;

  assign io_wr = !bus_mem && bus_wr;
  assign wr_lo = io_wr && (io_port == PORT_BASE);
  assign wr_hi = io_wr && (io_port == PORT_BASE + 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_lo <= LO_RESET;
      page_hi <= HI_RESET;
    end else begin
      if (wr_lo) page_lo <= cpu_data;
      if (wr_hi) page_hi <= cpu_data;
    end
  end

  assign sel_page = cpu_addr[15] ? page_hi : page_lo;
  assign kb_idx   = {1'b0, cpu_addr[15:10]};
  assign in_prom  = (kb_idx >= KB_FIRST) && (kb_idx < KB_END);

  assign bus_addr = bus_mem ? {4'h0, sel_page[7:2], cpu_addr[13:0]}
                            : {16'h0000, io_port};
  assign prom_sel = bus_mem && !bus_wr && !page_hi[0] && in_prom;
  assign addr_led = bus_addr[19:16];

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  boot_prom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!past_ok && bus_mem && !bus_wr && cpu_addr[15:12] == 4'hF) |-> prom_sel);

  // R4
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_lo) && bus_mem && !cpu_addr[15])
      |-> (bus_addr[19:14] == $past(cpu_data[7:2])));

  // R4
  hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_hi) && bus_mem && cpu_addr[15])
      |-> (bus_addr[19:14] == $past(cpu_data[7:2])));

  // R8
  prom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_hi && cpu_data[0])) |-> !prom_sel);

  // R9
  prom_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prom_sel |-> (bus_mem && !bus_wr));

  // R6
  io_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mem |-> (bus_addr[23:8] == 16'h0000));

  // R5
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr[23:20] == 4'h0);
endmodule

// File: tb/page_window_xlat_bench.sv
module page_window_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0;
  logic        bus_mem = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  cpu_data = 8'h0;
  logic [7:0]  io_port = 8'h0;
  logic [23:0] bus_addr;
  logic        prom_sel;
  logic [3:0]  addr_led;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_lo, m_hi;

  always #10 clk = ~clk;

  page_window_xlat u_page_window_xlat (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bus_mem(bus_mem),
    .bus_wr(bus_wr), .cpu_data(cpu_data), .io_port(io_port),
    .bus_addr(bus_addr), .prom_sel(prom_sel), .addr_led(addr_led));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    int ea, eprom, a;
    a = int'(cpu_addr);
    if (bus_mem) begin
      int pg;
      pg = (a >= 32768) ? m_hi : m_lo;
      ea = (pg / 4) * 16384 + (a % 16384);
      eprom = (!bus_wr && (m_hi % 2 == 0) && a >= 16'hF000) ? 1 : 0;
    end else begin
      ea = int'(io_port);
      eprom = 0;
    end
    check(req, "bus_addr", int'(bus_addr), ea);
    check(req, "prom_sel", int'(prom_sel), eprom);
    check("R10", "addr_led", int'(addr_led), (ea / 65536) % 16);
  endtask

  task automatic step(string req, bit mem, bit wr, logic [15:0] a,
                      logic [7:0] d, logic [7:0] p);
    cpu_addr = a; bus_mem = mem; bus_wr = wr; cpu_data = d; io_port = p;
    @(negedge clk);
    compare(req);
    @(posedge clk);
    if (!mem && wr && p == 8'hD2) m_lo = int'(d);
    if (!mem && wr && p == 8'hD3) m_hi = int'(d);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_lo = 8'h00; m_hi = 8'h0C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1", 1, 0, 16'hF123, 8'h00, 8'h00);
    step("R1", 1, 0, 16'h0000, 8'h00, 8'h00);
    step("R2", 1, 0, 16'h1234, 8'h00, 8'h00);
    step("R4", 0, 1, 16'h0000, 8'hFC, 8'hD2);
    step("R2", 1, 0, 16'h0000, 8'h00, 8'h00);
    step("R2", 1, 0, 16'h7ABC, 8'h00, 8'h00);
    step("R4", 0, 1, 16'h0000, 8'h14, 8'hD3);
    step("R3", 1, 0, 16'h8123, 8'h00, 8'h00);
    step("R7", 1, 0, 16'hF800, 8'h00, 8'h00);
    step("R8", 0, 1, 16'h0000, 8'h15, 8'hD3);
    step("R8", 1, 0, 16'hF800, 8'h00, 8'h00);
    step("R8", 1, 0, 16'hC001, 8'h00, 8'h00);
    step("R8", 0, 1, 16'h0000, 8'h14, 8'hD3);
    step("R8", 1, 0, 16'hF800, 8'h00, 8'h00);
    step("R4", 0, 1, 16'h0000, 8'hFF, 8'hD4);
    step("R4", 1, 0, 16'h0010, 8'h00, 8'h00);
    step("R4", 0, 0, 16'h0000, 8'hFF, 8'hD2);
    step("R4", 1, 1, 16'h0020, 8'hFF, 8'hD2);
    step("R4", 1, 0, 16'h8020, 8'h00, 8'h00);
    step("R9", 1, 1, 16'hF000, 8'h00, 8'h00);
    step("R9", 0, 0, 16'hF000, 8'h00, 8'h33);
    step("R6", 0, 0, 16'hABCD, 8'h00, 8'h33);
    step("R7", 1, 0, 16'hEFFF, 8'h00, 8'h00);
    step("R7", 1, 0, 16'hF000, 8'h00, 8'h00);
    step("R7", 1, 0, 16'hFFFF, 8'h00, 8'h00);
    step("R8", 0, 1, 16'h0000, 8'hFF, 8'hD2);
    step("R8", 1, 0, 16'h2345, 8'h00, 8'h00);
    step("R8", 0, 1, 16'h0000, 8'hFC, 8'hD2);
    step("R8", 1, 0, 16'h2345, 8'h00, 8'h00);
    step("R5", 0, 1, 16'h0000, 8'hFC, 8'hD3);
    step("R5", 1, 0, 16'hFFFF, 8'h00, 8'h00);
    step("R10", 1, 0, 16'h3FFF, 8'h00, 8'h00);
    step("R1", 1, 0, 16'hC000, 8'h00, 8'h00);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    m_lo = 8'h00; m_hi = 8'h0C;
    step("R1", 1, 0, 16'hFABC, 8'h00, 8'h00);
    step("R1", 1, 0, 16'h1111, 8'h00, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule